// File: doc/BRIEF.md
# GPIO Controller with Grouped Interrupts

This block is a memory-mapped general-purpose I/O and pin-configuration controller for a parameterised number of pins (64 by default). Every pin owns one 32-bit configuration word that sets its output value, its operating mode and interrupt trigger, an alternate-function select, a pull setting, an input-enable flag, the interrupt group it reports to, and a lock flag. The pull, alternate-function and input-enable fields are only exported as outputs for the pad ring. Output data and output enable are driven directly from the configuration.

Pin inputs pass through a two-flop synchronizer. The block then detects level and edge conditions according to each pin's mode and latches them into pending banks, one bank per interrupt group. Software reads a pending word and clears bits by writing ones to them. Each group drives its own interrupt line, which is high while any bit of that group's bank is set.

Access is through a simple register bus. A request is accepted on any cycle in which `req_valid_i` is high. `req_ready_o` is tied high, so the bus never applies back-pressure. Read data comes back with `rsp_valid_o` exactly one cycle after the read is accepted.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Pin n's configuration word is at byte address 4*n. Its fields are: bit 0 data, bits 3:1 mode, bits 6:5 alternate-function select, bits 8:7 pull, bit 9 input enable, bits 18:16 interrupt group, bit 21 lock. A read returns the stored fields, with every other bit reading 0.
- R2: After reset, every configuration word holds mode 7 with all other fields 0, every pending bit is 0 and every interrupt line is low.
- R3: `pin_out_o` follows the data bit. `pin_oe_o` is high only when the mode is 1 and the alternate-function select is 0. The pull (0 none, 1 down, 2 strong up, 3 up), select and input-enable fields appear unchanged on their output buses.
- R4: When the mode is not 1, bit 0 of a read returns the synchronized input level, which is visible within three clocks of a change at the pin.
- R5: In mode 2 (high level) or mode 3 (low level), the pin's pending bit is set while the condition holds. If the bit is cleared while the condition still holds, it reads back as set.
- R6: Mode 4 sets the pending bit on a rising edge, mode 5 on a falling edge and mode 6 on either edge. Once cleared, the bit stays clear until the next qualifying edge.
- R7: A pin in mode 0, mode 1 or mode 7 never sets a pending bit.
- R8: Each event sets the bit of the group named in the pin's group field. The pending word for pin p in group g is at 0x800 + 0x40*g + 4*(p/32), and bit p mod 32 of that word belongs to pin p.
- R9: Writing a 1 to a pending bit clears it. Bits written as 0 keep their value.
- R10: `irq_o[g]` is high exactly when at least one pending bit of group g is set.
- R11: Once the lock bit of a pin is written as 1, later writes to that pin's configuration word are ignored until reset.
- R12: `req_ready_o` is always high. A read accepted in one cycle returns its data with `rsp_valid_o` high in the next cycle, and `rsp_valid_o` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Bus request valid |
| req_ready_o | output | 1 | Bus request ready, always high |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_addr_i | input | 12 | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| pin_i | input | NUM_PINS | Raw pin input levels |
| pin_out_o | output | NUM_PINS | Output value per pin |
| pin_oe_o | output | NUM_PINS | Output enable per pin |
| pin_ie_o | output | NUM_PINS | Input enable per pin |
| pin_pull_o | output | 2*NUM_PINS | Pull code, two bits per pin |
| pin_periph_o | output | 2*NUM_PINS | Alternate-function select, two bits per pin |
| irq_o | output | NUM_GROUPS | Interrupt line per group |

## Verification
The assertions assume that the bus issues word-aligned addresses and that the only way a pending bit can drop is through a bus write to the pending region. They also assume that pin inputs may change at any time relative to the clock. The stimulus drives every pin and bus input on the falling edge. It holds each pin level for at least five clocks, so the synchronizer and the edge history settle before the bench predicts the pending state. In the random phase every lock bit is kept at 0, so the configuration stays writable, and locking is exercised once in a directed test near the end.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [2:0] {
    MD_NONE   = 3'd0,
    MD_OUT    = 3'd1,
    MD_LVL_HI = 3'd2,
    MD_LVL_LO = 3'd3,
    MD_RISE   = 3'd4,
    MD_FALL   = 3'd5,
    MD_BOTH   = 3'd6,
    MD_OFF    = 3'd7
  } pin_mode_e;

  typedef struct packed {
    logic       lock;
    logic [2:0] grp;
    logic       ie;
    logic [1:0] pull;
    logic [1:0] periph;
    pin_mode_e  mode;
    logic       data;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{lock: 1'b0, grp: 3'd0, ie: 1'b0,
                                     pull: 2'd0, periph: 2'd0,
                                     mode: MD_OFF, data: 1'b0};

  function automatic logic [31:0] cfg_to_word(pin_cfg_t c);
    logic [31:0] w;
    w        = '0;
    w[0]     = c.data;
    w[3:1]   = c.mode;
    w[6:5]   = c.periph;
    w[8:7]   = c.pull;
    w[9]     = c.ie;
    w[18:16] = c.grp;
    w[21]    = c.lock;
    return w;
  endfunction

  function automatic pin_cfg_t word_to_cfg(logic [31:0] w);
    pin_cfg_t c;
    c.data   = w[0];
    c.mode   = pin_mode_e'(w[3:1]);
    c.periph = w[6:5];
    c.pull   = w[8:7];
    c.ie     = w[9];
    c.grp    = w[18:16];
    c.lock   = w[21];
    return c;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, lvl_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      lvl_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= d_i;
      lvl_q  <= meta_q;
      prev_q <= lvl_q;
    end
  end

  assign lvl_o  = lvl_q;
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_irq_pkg::*;
(
  input  pin_mode_e mode_i,
  input  logic      lvl_i,
  input  logic      prev_i,
  output logic      evt_o
);
  always_comb begin
    unique case (mode_i)
      MD_LVL_HI: evt_o = lvl_i;
      MD_LVL_LO: evt_o = !lvl_i;
      MD_RISE:   evt_o = lvl_i && !prev_i;
      MD_FALL:   evt_o = !lvl_i && prev_i;
      MD_BOTH:   evt_o = lvl_i ^ prev_i;
      default:   evt_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS   = 64,
  parameter int NUM_GROUPS = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic                    req_write_i,
  input  logic [11:0]             req_addr_i,
  input  logic [31:0]             req_wdata_i,
  output logic                    rsp_valid_o,
  output logic [31:0]             rsp_rdata_o,
  input  logic [NUM_PINS-1:0]     pin_i,
  output logic [NUM_PINS-1:0]     pin_out_o,
  output logic [NUM_PINS-1:0]     pin_oe_o,
  output logic [NUM_PINS-1:0]     pin_ie_o,
  output logic [2*NUM_PINS-1:0]   pin_pull_o,
  output logic [2*NUM_PINS-1:0]   pin_periph_o,
  output logic [NUM_GROUPS-1:0]   irq_o
);
  localparam int WORDS   = (NUM_PINS + 31) / 32;
  localparam int PIN_AW  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  pin_cfg_t                          cfg_q [NUM_PINS];
  logic [NUM_PINS-1:0]               lvl, prev, evt;
  logic [NUM_GROUPS-1:0][NUM_PINS-1:0] pend_q, pend_d, clr;
  logic [NUM_GROUPS*NUM_PINS-1:0]    pend_flat;
  logic [NUM_PINS*32-1:0]            cfg_img;
  logic                              cfg_hit, pend_hit;
  logic [PIN_AW-1:0]                 pin_idx;
  logic [31:0]                       rd_data;
  logic                              unused_wdata;

  assign unused_wdata = ^{req_wdata_i[31:22], req_wdata_i[20:19],
                          req_wdata_i[15:10], req_wdata_i[4]};

  assign req_ready_o = 1'b1;
  assign cfg_hit  = !req_addr_i[11] && (req_addr_i[1:0] == 2'b00) &&
                    (req_addr_i[10:2] < 9'(NUM_PINS));
  assign pend_hit = req_addr_i[11] && (req_addr_i[10:9] == 2'b00) &&
                    (req_addr_i[1:0] == 2'b00);
  assign pin_idx  = req_addr_i[PIN_AW+1:2];

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (pin_i),
    .lvl_o (lvl), .prev_o (prev)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_evt_detect u_evt (
      .mode_i (cfg_q[p].mode), .lvl_i (lvl[p]), .prev_i (prev[p]),
      .evt_o  (evt[p])
    );
    assign pin_out_o[p]          = cfg_q[p].data;
    assign pin_oe_o[p]           = (cfg_q[p].mode == MD_OUT) && (cfg_q[p].periph == 2'd0);
    assign pin_ie_o[p]           = cfg_q[p].ie;
    assign pin_pull_o[2*p +: 2]  = cfg_q[p].pull;
    assign pin_periph_o[2*p +: 2] = cfg_q[p].periph;
    assign cfg_img[32*p +: 32]   = cfg_to_word(cfg_q[p]);
  end

  // Configuration words: write unless locked.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PINS; p++) cfg_q[p] <= CFG_RESET;
    end else if (req_valid_i && req_write_i && cfg_hit && !cfg_q[pin_idx].lock) begin
      cfg_q[pin_idx] <= word_to_cfg(req_wdata_i);
    end
  end

  // Write-one-to-clear mask per group and word.
  always_comb begin
    clr = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      for (int w = 0; w < WORDS; w++) begin
        if (req_valid_i && req_write_i && pend_hit &&
            req_addr_i[8:6] == 3'(g) && req_addr_i[5:2] == 4'(w))
          clr[g][w*32 +: 32] = req_wdata_i;
      end
    end
  end

  // New events take priority over a clear in the same cycle.
  always_comb begin
    for (int g = 0; g < NUM_GROUPS; g++) begin
      for (int p = 0; p < NUM_PINS; p++) begin
        pend_d[g][p] = (pend_q[g][p] && !clr[g][p]) ||
                       (evt[p] && cfg_q[p].grp == 3'(g));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign irq_o[g] = |pend_q[g];
    assign pend_flat[g*NUM_PINS +: NUM_PINS] = pend_q[g];
  end

  // Read multiplexer.
  always_comb begin
    rd_data = '0;
    if (cfg_hit) begin
      rd_data = cfg_to_word(cfg_q[pin_idx]);
      if (cfg_q[pin_idx].mode != MD_OUT) rd_data[0] = lvl[pin_idx];
    end else if (pend_hit) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        for (int w = 0; w < WORDS; w++) begin
          if (req_addr_i[8:6] == 3'(g) && req_addr_i[5:2] == 4'(w))
            rd_data = pend_q[g][w*32 +: 32];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i && !req_write_i;
      if (req_valid_i && !req_write_i) rsp_rdata_o <= rd_data;
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NUM_PINS   = 64,
  parameter int NUM_GROUPS = 8
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           req_valid_i,
  input logic                           req_write_i,
  input logic [11:0]                    req_addr_i,
  input logic                           rsp_valid_o,
  input logic [NUM_GROUPS*NUM_PINS-1:0] pend_flat,
  input logic [NUM_PINS*32-1:0]         cfg_img
);
  logic [NUM_PINS-1:0] pend_any;

  always_comb begin
    pend_any = '0;
    for (int g = 0; g < NUM_GROUPS; g++)
      pend_any = pend_any | pend_flat[g*NUM_PINS +: NUM_PINS];
  end

  AST_CLEAR_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(pend_flat) & ~pend_flat)) |-> $past(req_valid_i && req_write_i && req_addr_i[11])); // R9

  AST_READ_RESPONSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o); // R12

  AST_NO_SPURIOUS_RESPONSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_write_i) |=> !rsp_valid_o); // R12

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    AST_LOCK_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_img[32*p + 21] |=> $stable(cfg_img[32*p +: 32])); // R11

    AST_QUIET_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(cfg_img[32*p+1 +: 3] inside {3'd0, 3'd1, 3'd7}) |-> !$rose(pend_any[p])); // R7
  end
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_PINS(NUM_PINS), .NUM_GROUPS(NUM_GROUPS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_addr_i  (req_addr_i),
  .rsp_valid_o (rsp_valid_o),
  .pend_flat   (pend_flat),
  .cfg_img     (cfg_img)
);

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb;
  localparam int NP = 64;
  localparam int NG = 8;
  localparam int NW = NP / 32;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic              req_write_i = 1'b0;
  logic [11:0]       req_addr_i = '0;
  logic [31:0]       req_wdata_i = '0;
  logic              rsp_valid_o;
  logic [31:0]       rsp_rdata_o;
  logic [NP-1:0]     pin_i = '0;
  logic [NP-1:0]     pin_out_o, pin_oe_o, pin_ie_o;
  logic [2*NP-1:0]   pin_pull_o, pin_periph_o;
  logic [NG-1:0]     irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  bit [2:0] m_mode [NP];
  bit [2:0] m_grp  [NP];
  bit       m_lvl  [NP];
  bit       m_pend [NG][NP];

  always #2.5 clk_i = ~clk_i;

  gpio_irq_ctrl #(.NUM_PINS(NP), .NUM_GROUPS(NG)) u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit [2:0] mode, bit data, bit [1:0] per,
                                     bit [1:0] pull, bit ie, bit [2:0] grp, bit lock);
    logic [31:0] w = '0;
    w[0] = data; w[3:1] = mode; w[6:5] = per; w[8:7] = pull;
    w[9] = ie; w[18:16] = grp; w[21] = lock;
    return w;
  endfunction

  function automatic logic [11:0] pend_addr(int g, int w);
    return 12'(12'h800 + g * 12'h40 + w * 4);
  endfunction

  function automatic bit event_of(bit [2:0] mode, bit old_l, bit new_l);
    case (mode)
      3'd2: return new_l;
      3'd3: return !new_l;
      3'd4: return !old_l && new_l;
      3'd5: return old_l && !new_l;
      3'd6: return old_l != new_l;
      default: return 1'b0;
    endcase
  endfunction

  task automatic bus_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_valid_i = 1; req_write_i = 1; req_addr_i = a; req_wdata_i = d;
    @(negedge clk_i);
    req_valid_i = 0; req_write_i = 0;
  endtask

  task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_valid_i = 1; req_write_i = 0; req_addr_i = a;
    @(negedge clk_i);
    req_valid_i = 0;
    check("R12 rsp_valid", 32'(rsp_valid_o), 32'd1);
    d = rsp_rdata_o;
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0; pin_i = '0;
    wait_clk(3);
    rst_ni = 1;
    wait_clk(2);
  endtask

  task automatic clear_all();
    for (int g = 0; g < NG; g++)
      for (int w = 0; w < NW; w++) bus_wr(pend_addr(g, w), 32'hFFFF_FFFF);
    for (int g = 0; g < NG; g++)
      for (int p = 0; p < NP; p++)
        m_pend[g][p] = (m_grp[p] == 3'(g)) && event_of(m_mode[p], m_lvl[p], m_lvl[p]) &&
                       (m_mode[p] == 3'd2 || m_mode[p] == 3'd3);
  endtask

  task automatic compare_all(string tag);
    logic [31:0] rd;
    for (int g = 0; g < NG; g++) begin
      logic any = 0;
      for (int w = 0; w < NW; w++) begin
        logic [31:0] exp = '0;
        for (int b = 0; b < 32; b++) exp[b] = m_pend[g][w*32+b];
        any |= |exp;
        bus_rd(pend_addr(g, w), rd);
        check(tag, rd, exp);
      end
      check("R10 irq line", 32'(irq_o[g]), 32'(any));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    do_reset();

    // R2 reset state
    bus_rd(12'h000, rd);
    check("R2 reset cfg", rd, 32'h0000_000E);
    check("R2 reset irq", 32'(irq_o), 32'd0);
    check("R12 ready", 32'(req_ready_o), 32'd1);

    // R1 field layout and R3 exported fields
    bus_wr(12'(4*10), mk(3'd7, 0, 2'd2, 2'd3, 1, 3'd5, 0));
    bus_rd(12'(4*10), rd);
    check("R1 readback", rd, mk(3'd7, 0, 2'd2, 2'd3, 1, 3'd5, 0));
    check("R3 pull out", 32'(pin_pull_o[21:20]), 32'd3);
    check("R3 periph out", 32'(pin_periph_o[21:20]), 32'd2);
    check("R3 ie out", 32'(pin_ie_o[10]), 32'd1);

    // R3 output drive
    bus_wr(12'(4*5), mk(3'd1, 1, 2'd0, 2'd0, 0, 3'd0, 0));
    wait_clk(1);
    check("R3 out data", 32'(pin_out_o[5]), 32'd1);
    check("R3 oe gpio", 32'(pin_oe_o[5]), 32'd1);
    bus_rd(12'(4*5), rd);
    check("R3 data readback", 32'(rd[0]), 32'd1);
    bus_wr(12'(4*5), mk(3'd1, 1, 2'd1, 2'd0, 0, 3'd0, 0));
    wait_clk(1);
    check("R3 oe alt func", 32'(pin_oe_o[5]), 32'd0);

    // R4 live level and R7 quiet modes
    bus_wr(12'(4*8), mk(3'd0, 0, 2'd0, 2'd0, 1, 3'd0, 0));
    @(negedge clk_i); pin_i[7] = 1; pin_i[5] = 1; pin_i[8] = 1;
    wait_clk(4);
    bus_rd(12'(4*7), rd);
    check("R4 live level", 32'(rd[0]), 32'd1);
    @(negedge clk_i); pin_i[7] = 0; pin_i[5] = 0; pin_i[8] = 0;
    wait_clk(4);
    bus_rd(12'(4*7), rd);
    check("R4 live level low", 32'(rd[0]), 32'd0);
    bus_rd(pend_addr(0, 0), rd);
    check("R7 no pending", rd, 32'd0);
    check("R7 no irq", 32'(irq_o), 32'd0);

    // R5 level-high on pin 40, group 3
    bus_wr(12'(4*40), mk(3'd2, 0, 2'd0, 2'd0, 1, 3'd3, 0));
    @(negedge clk_i); pin_i[40] = 1;
    wait_clk(5);
    bus_rd(pend_addr(3, 1), rd);
    check("R8 level pend word", rd, 32'h0000_0100);
    check("R10 irq group3", 32'(irq_o), 32'h08);
    bus_wr(pend_addr(3, 1), 32'h0000_0100);
    bus_rd(pend_addr(3, 1), rd);
    check("R5 level re-asserts", rd, 32'h0000_0100);
    @(negedge clk_i); pin_i[40] = 0;
    wait_clk(5);
    bus_wr(pend_addr(3, 1), 32'h0000_0000);
    bus_rd(pend_addr(3, 1), rd);
    check("R9 zero write keeps", rd, 32'h0000_0100);
    bus_wr(pend_addr(3, 1), 32'h0000_0100);
    bus_rd(pend_addr(3, 1), rd);
    check("R9 clear", rd, 32'd0);
    check("R10 irq low", 32'(irq_o), 32'd0);

    // R6 rising edge on pin 33, group 1
    bus_wr(12'(4*33), mk(3'd4, 0, 2'd0, 2'd0, 1, 3'd1, 0));
    @(negedge clk_i); pin_i[33] = 1;
    wait_clk(5);
    bus_rd(pend_addr(1, 1), rd);
    check("R6 rise pend", rd, 32'h0000_0002);
    bus_wr(pend_addr(1, 1), 32'hFFFF_FFFF);
    bus_rd(pend_addr(1, 1), rd);
    check("R6 stays clear", rd, 32'd0);
    @(negedge clk_i); pin_i[33] = 0;
    wait_clk(5);
    bus_rd(pend_addr(1, 1), rd);
    check("R6 fall ignored in rise mode", rd, 32'd0);

    // R11 lock
    bus_wr(12'(4*12), mk(3'd7, 0, 2'd1, 2'd0, 0, 3'd2, 1));
    bus_wr(12'(4*12), mk(3'd1, 1, 2'd0, 2'd0, 0, 3'd0, 0));
    bus_rd(12'(4*12), rd);
    check("R11 locked", rd, mk(3'd7, 0, 2'd1, 2'd0, 0, 3'd2, 1));

    // Random phase: R5 R6 R7 R8 R9 R10
    do_reset();
    for (int p = 0; p < NP; p++) begin
      m_mode[p] = 3'($urandom_range(0, 7));
      m_grp[p]  = 3'($urandom_range(0, 7));
      m_lvl[p]  = 0;
      bus_wr(12'(4*p), mk(m_mode[p], 0, 2'd0, 2'd0, 1, m_grp[p], 0));
    end
    wait_clk(5);
    clear_all();
    compare_all("R8 random init");
    for (int s = 0; s < 30; s++) begin
      int p = $urandom_range(0, NP-1);
      bit old_l = m_lvl[p];
      @(negedge clk_i);
      pin_i[p] = !old_l;
      m_lvl[p] = !old_l;
      wait_clk(5);
      if (event_of(m_mode[p], old_l, m_lvl[p])) m_pend[m_grp[p]][p] = 1;
      compare_all("R6 random step");
      if (s % 5 == 4) begin
        clear_all();
        compare_all("R5 random after clear");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule